// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with APB Register Interface

This block is a watchdog peripheral that sits on an APB bus. A down-counter decrements on every cycle where the watchdog tick enable is high. The first time the count runs out, the block raises an interrupt and starts counting again from the reload value. If software does not acknowledge that interrupt before the count runs out a second time, the block raises a reset request and freezes the counter.

Software programs the block through a small register file. It has a reload value, a readable live count and a two-bit enable word that masks the interrupt and reset outputs. Writing to the acknowledge register clears the interrupt and restarts the count. A key register blocks every other write until the correct magic word is written. A test mode lets software drive both outputs directly, and a bank of fixed identification bytes can be read back.

The parameter `STICKY_CTRL` selects a variant. In that variant, once the interrupt enable has been set, later writes to the enable word are ignored. The test-mode registers also decode as unused.

The counter is a small state machine with three named states. In COUNTING it decrements on each tick. A tick while the count is 1 or 0 is an expiry. On the first expiry (raw interrupt clear) the block sets the raw interrupt and moves to RELOAD_WAIT. On the next tick in RELOAD_WAIT it copies the reload value into the count and returns to COUNTING. On an expiry while the raw interrupt is already set, the block sets the reset status and moves to HALTED, where ticks have no effect. A reload write moves any state to COUNTING. An acknowledge write moves RELOAD_WAIT to COUNTING and leaves HALTED where it is.

Top module: `wdt_apb_top`

## Requirements
- R1: After reset, the reload and count registers read 0xFFFFFFFF. The enable word, raw status, lock, test control and test output all read 0, and both outputs are low.
- R2: A write to the reload register (offset 0x000) sets both the reload value and the count to the written data and starts counting. After that, each tick lowers the count (offset 0x004) by exactly one.
- R3: An expiry with the raw interrupt clear sets raw status bit 0 (offset 0x010) and leaves the count at 0. The next tick reloads the count from the reload value.
- R4: An expiry with the raw interrupt already set sets the reset status and halts the counter. Further ticks leave the count unchanged.
- R5: Any write to the acknowledge register (offset 0x00C) clears the raw interrupt and copies the reload value into the count. It does not leave the HALTED state.
- R6: The enable word is at offset 0x008. Bit 0 gates the raw interrupt onto `irq_o` and bit 1 gates the reset status onto `rst_req_o`. The masked status (offset 0x014) reads the gated interrupt.
- R7: Writing 0x1ACCE551 to the key register (offset 0xC00) unlocks the block, and any other value locks it. The key register reads 1 when locked and 0 when unlocked. While locked, writes to every other offset are ignored.
- R8: When test control bit 0 (offset 0xF00) is set, `rst_req_o` follows test output bit 0 and `irq_o` follows test output bit 1 (offset 0xF04).
- R9: The twelve words from 0xFD0 to 0xFFC read the bytes 04,00,00,00,24,B8,1B,00,0D,F0,05,B1, in that order.
- R10: Reads of the acknowledge register or of any undefined offset return 0. Writes to read-only offsets have no effect. `pready` is always 1 and `pslverr` is always 0.
- R11: With STICKY_CTRL=1, writes to the enable word are ignored once bit 0 is set. The test control and test output registers read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Watchdog tick enable, one count per high cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never signals an error |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
A wrong state in the counter FSM shows up at the ports within one tick. A missed RELOAD_WAIT step leaves the count at 0 instead of the reload value. A missed HALTED state lets the count keep moving. A stuck raw flag turns the next expiry into a premature reset request. An error in the lock or the sticky enable shows up on the first read-back after a write that should have been blocked. An error in the output gating shows up on `irq_o` or `rst_req_o` in the same cycle that the enable word or test register changes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        COUNTING    = 2'd0,
        RELOAD_WAIT = 2'd1,
        HALTED      = 2'd2
    } cnt_state_e;

    localparam logic [11:0] OFF_RELOAD = 12'h000;
    localparam logic [11:0] OFF_COUNT  = 12'h004;
    localparam logic [11:0] OFF_ENABLE = 12'h008;
    localparam logic [11:0] OFF_ACK    = 12'h00C;
    localparam logic [11:0] OFF_RAW    = 12'h010;
    localparam logic [11:0] OFF_MASKED = 12'h014;
    localparam logic [11:0] OFF_KEY    = 12'hC00;
    localparam logic [11:0] OFF_TCTL   = 12'hF00;
    localparam logic [11:0] OFF_TOUT   = 12'hF04;
    localparam logic [11:0] OFF_ID_LO  = 12'hFD0;
    localparam logic [11:0] OFF_ID_HI  = 12'hFFC;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        unique case (idx)
            4'd0:    return 8'h04;
            4'd4:    return 8'h24;
            4'd5:    return 8'hB8;
            4'd6:    return 8'h1B;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic             ack_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] reload,
    output logic             raw_irq,
    output logic             rst_stat,
    output logic             halted
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, rl_q, rl_d;
    logic             raw_q, raw_d, rs_q, rs_d;
    logic             at_end;

    assign at_end = (cnt_q == ONE) || (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= COUNTING;
            cnt_q <= '1;
            rl_q  <= '1;
            raw_q <= 1'b0;
            rs_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            rl_q  <= rl_d;
            raw_q <= raw_d;
            rs_q  <= rs_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        rl_d  = rl_q;
        raw_d = raw_q;
        rs_d  = rs_q;
        if (load_wr) begin
            rl_d  = wdata;
            cnt_d = wdata;
            st_d  = COUNTING;
        end else if (ack_wr) begin
            raw_d = 1'b0;
            cnt_d = rl_q;
            if (st_q != HALTED) st_d = COUNTING;
        end else if (tick) begin
            unique case (st_q)
                COUNTING: begin
                    if (at_end) begin
                        cnt_d = '0;
                        if (!raw_q) begin
                            raw_d = 1'b1;
                            st_d  = RELOAD_WAIT;
                        end else begin
                            rs_d = 1'b1;
                            st_d = HALTED;
                        end
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                RELOAD_WAIT: begin
                    cnt_d = rl_q;
                    st_d  = COUNTING;
                end
                HALTED: ;
                default: st_d = COUNTING;
            endcase
        end
    end

    assign cnt      = cnt_q;
    assign reload   = rl_q;
    assign raw_irq  = raw_q;
    assign rst_stat = rs_q;
    assign halted   = (st_q == HALTED);
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 12,
    parameter bit STICKY_CTRL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  reload,
    input  logic              raw_irq,
    input  logic              rst_stat,
    output logic              load_wr,
    output logic              ack_wr,
    output logic [1:0]        enable,
    output logic              locked,
    output logic              tmode,
    output logic [31:0]       rdata,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam bit TEST_REGS = !STICKY_CTRL;

    logic [11:0] a;
    logic        wr_ok, en_frozen;
    logic [1:0]  en_q, tout_q;
    logic        lock_q, tctl_q;
    logic [3:0]  id_idx;
    logic [11:0] id_off;

    assign a         = {addr[11:2], 2'b00};
    assign wr_ok     = wr && (!lock_q || a == OFF_KEY);
    assign load_wr   = wr_ok && (a == OFF_RELOAD);
    assign ack_wr    = wr_ok && (a == OFF_ACK);
    assign en_frozen = STICKY_CTRL && en_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 2'b00;
            lock_q <= 1'b0;
            tctl_q <= 1'b0;
            tout_q <= 2'b00;
        end else if (wr_ok) begin
            if (a == OFF_ENABLE && !en_frozen) en_q <= wdata[1:0];
            if (a == OFF_KEY) lock_q <= (wdata != UNLOCK_KEY);
            if (TEST_REGS && a == OFF_TCTL) tctl_q <= wdata[0];
            if (TEST_REGS && a == OFF_TOUT) tout_q <= wdata[1:0];
        end
    end

    assign id_off = a - OFF_ID_LO;
    assign id_idx = id_off[5:2];

    always_comb begin
        rdata = '0;
        if (a >= OFF_ID_LO && a <= OFF_ID_HI) begin
            rdata = {24'd0, id_byte(id_idx)};
        end else begin
            unique case (a)
                OFF_RELOAD: rdata = 32'(reload);
                OFF_COUNT:  rdata = 32'(cnt);
                OFF_ENABLE: rdata = {30'd0, en_q};
                OFF_RAW:    rdata = {31'd0, raw_irq};
                OFF_MASKED: rdata = {31'd0, raw_irq & en_q[0]};
                OFF_KEY:    rdata = {31'd0, lock_q};
                OFF_TCTL:   rdata = TEST_REGS ? {31'd0, tctl_q} : 32'd0;
                default:    rdata = '0;
            endcase
        end
    end

    assign irq_o     = tctl_q ? tout_q[1] : (raw_irq & en_q[0]);
    assign rst_req_o = tctl_q ? tout_q[0] : (rst_stat & en_q[1]);
    assign enable    = en_q;
    assign locked    = lock_q;
    assign tmode     = tctl_q;
endmodule

// File: rtl/wdt_apb_top.sv
module wdt_apb_top #(
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 12,
    parameter bit STICKY_CTRL = 1'b0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              tick_en,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq_o,
    output logic              rst_req_o
);
    logic             bus_wr, load_wr, ack_wr;
    logic [CNT_W-1:0] cnt_w, reload_w;
    logic             raw_w, rstat_w, halted_w, lock_w, tmode_w;
    logic [1:0]       enable_w;

    assign bus_wr  = psel && penable && pwrite;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(pclk), .rst_n(presetn), .tick(tick_en),
        .load_wr(load_wr), .ack_wr(ack_wr), .wdata(pwdata[CNT_W-1:0]),
        .cnt(cnt_w), .reload(reload_w), .raw_irq(raw_w),
        .rst_stat(rstat_w), .halted(halted_w)
    );

    wdt_regfile #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .STICKY_CTRL(STICKY_CTRL)) u_regs (
        .clk(pclk), .rst_n(presetn), .wr(bus_wr), .addr(paddr), .wdata(pwdata),
        .cnt(cnt_w), .reload(reload_w), .raw_irq(raw_w), .rst_stat(rstat_w),
        .load_wr(load_wr), .ack_wr(ack_wr), .enable(enable_w), .locked(lock_w),
        .tmode(tmode_w), .rdata(prdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );
endmodule

// File: rtl/wdt_apb_checker.sv
module wdt_apb_checker #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] paddr,
    input logic              load_wr,
    input logic              ack_wr,
    input logic [CNT_W-1:0]  cnt,
    input logic              raw,
    input logic              rstat,
    input logic              halted,
    input logic              locked,
    input logic [1:0]        enable,
    input logic              tmode,
    input logic              irq
);
    logic quiet, en_wr;
    assign quiet = !load_wr && !ack_wr;
    assign en_wr = bus_wr && (paddr[11:2] == 10'h002);

    AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && tick && quiet && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1))); // R2
    AST_FIRST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && tick && quiet && cnt == CNT_W'(1) && !raw) |=> (raw && !halted)); // R3
    AST_SECOND_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && tick && quiet && cnt == CNT_W'(1) && raw) |=> (rstat && halted)); // R4
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && quiet) |=> $stable(cnt)); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> !raw); // R5
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && !tmode) |-> enable[0]); // R6
    AST_LOCK_BLOCKS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && en_wr) |=> $stable(enable)); // R7
endmodule

bind wdt_apb_top wdt_apb_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(pclk), .rst_n(presetn), .tick(tick_en), .bus_wr(bus_wr), .paddr(paddr),
    .load_wr(load_wr), .ack_wr(ack_wr), .cnt(cnt_w), .raw(raw_w), .rstat(rstat_w),
    .halted(halted_w), .locked(lock_w), .enable(enable_w), .tmode(tmode_w), .irq(irq_o)
);

// File: tb/wdt_apb_top_test.sv
module wdt_apb_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        psel_a = 1'b0, psel_b = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] rd_a, rd_b;
    logic        rdy_a, err_a, irq_a, rst_a;
    logic        rdy_b, err_b, irq_b, rst_b;
    logic        use_b = 1'b0;
    int          total = 0, bad = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    wdt_apb_top uut (
        .pclk(clk), .presetn(rst_n), .tick_en(tick), .psel(psel_a), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd_a), .pready(rdy_a),
        .pslverr(err_a), .irq_o(irq_a), .rst_req_o(rst_a)
    );

    wdt_apb_top #(.STICKY_CTRL(1'b1)) uut_sticky (
        .pclk(clk), .presetn(rst_n), .tick_en(tick), .psel(psel_b), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd_b), .pready(rdy_b),
        .pslverr(err_b), .irq_o(irq_b), .rst_req_o(rst_b)
    );

    function automatic logic exp_out(input logic tm, input logic tbit,
                                     input logic stat, input logic en);
        return tm ? tbit : (stat & en);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        @(negedge clk);
        psel_a = !use_b; psel_b = use_b; pwrite = wr; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 r = use_b ? rd_b : rd_a;
        @(negedge clk);
        psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        bus(1'b1, a, d, dummy);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] r);
        bus(1'b0, a, 32'd0, r);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(12'h004, rv); check("R1 count", rv, 32'hFFFFFFFF);
        rd(12'h000, rv); check("R1 reload", rv, 32'hFFFFFFFF);
        rd(12'h008, rv); check("R1 enable", rv, 0);
        rd(12'hC00, rv); check("R1 lock", rv, 0);
        rd(12'hF00, rv); check("R1 tctl", rv, 0);
        check("R1 outputs", {irq_a, rst_a}, 0);
        // R2 reload and decrement
        wr(12'h000, 32'd5);
        rd(12'h004, rv); check("R2 loaded", rv, 5);
        ticks(3); rd(12'h004, rv); check("R2 dec", rv, 2);
        // R3 first expiry
        ticks(2); rd(12'h004, rv); check("R3 at zero", rv, 0);
        rd(12'h010, rv); check("R3 raw", rv, 1);
        check("R6 irq masked", irq_a, exp_out(0, 0, 1, 0));
        rd(12'h014, rv); check("R6 mis masked", rv, 0);
        ticks(1); rd(12'h004, rv); check("R3 reload", rv, 5);
        // R6 enable gating
        wr(12'h008, 32'd3);
        check("R6 irq on", irq_a, exp_out(0, 0, 1, 1));
        rd(12'h014, rv); check("R6 mis", rv, 1);
        // R5 ack
        ticks(2);
        wr(12'h00C, 32'hDEAD);
        rd(12'h010, rv); check("R5 raw clr", rv, 0);
        rd(12'h004, rv); check("R5 reload", rv, 5);
        check("R5 irq low", irq_a, 0);
        // R2 random patterns
        for (int i = 0; i < 10; i++) begin
            int unsigned n, k;
            n = $urandom_range(40, 2);
            k = $urandom_range(n - 1, 0);
            wr(12'h000, n);
            ticks(k);
            rd(12'h004, rv); check("R2 random", rv, n - k);
        end
        // R4 second expiry
        wr(12'h000, 32'd3);
        ticks(3); check("R3 irq", irq_a, 1);
        check("R4 no rst yet", rst_a, 0);
        ticks(1); ticks(3);
        check("R4 rst", rst_a, 1);
        rd(12'h004, rv); check("R4 at zero", rv, 0);
        ticks(5); rd(12'h004, rv); check("R4 halted", rv, 0);
        wr(12'h008, 32'd1);
        check("R6 rst masked", rst_a, exp_out(0, 0, 1, 0));
        check("R6 irq kept", irq_a, 1);
        wr(12'h00C, 0);
        rd(12'h004, rv); check("R5 ack in halt", rv, 3);
        ticks(2); rd(12'h004, rv); check("R5 still halted", rv, 3);
        wr(12'h000, 32'd4); ticks(1);
        rd(12'h004, rv); check("R2 restart", rv, 3);
        // R7 lock
        wr(12'hC00, 32'h0);
        rd(12'hC00, rv); check("R7 locked", rv, 1);
        wr(12'h000, 32'd9);
        rd(12'h000, rv); check("R7 blocked reload", rv, 4);
        wr(12'h008, 32'd0);
        rd(12'h008, rv); check("R7 blocked enable", rv, 1);
        wr(12'hC00, 32'h1ACCE551);
        rd(12'hC00, rv); check("R7 unlocked", rv, 0);
        // R8 test override
        wr(12'hF00, 1); wr(12'hF04, 2);
        check("R8 irq", {irq_a, rst_a}, 2'b10);
        wr(12'hF04, 1);
        check("R8 rst", {irq_a, rst_a}, 2'b01);
        wr(12'hF00, 0);
        check("R8 off", {irq_a, rst_a}, 2'b00);
        // R9 ID words
        rd(12'hFD0, rv); check("R9 first", rv, 32'h04);
        rd(12'hFE4, rv); check("R9 mid", rv, 32'hB8);
        rd(12'hFF0, rv); check("R9 cid0", rv, 32'h0D);
        rd(12'hFFC, rv); check("R9 last", rv, 32'hB1);
        // R10 undefined and read-only
        rd(12'h00C, rv); check("R10 ack read", rv, 0);
        rd(12'h200, rv); check("R10 undef", rv, 0);
        wr(12'h004, 32'd77);
        rd(12'h004, rv); check("R10 ro count", rv, 3);
        check("R10 pready/pslverr", {rdy_a, err_a}, 2'b10);
        // R11 sticky variant
        use_b = 1'b1;
        wr(12'h008, 1); wr(12'h008, 0);
        rd(12'h008, rv); check("R11 sticky", rv, 1);
        wr(12'hF00, 1); wr(12'hF04, 3);
        rd(12'hF00, rv); check("R11 tctl invalid", rv, 0);
        check("R11 no override", {irq_b, rst_b}, 2'b00);
        use_b = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule